// File: doc/BRIEF.md
# Flash Read-Mode Output Controller

This block is the read path of a parallel NOR flash command interface. A command byte written on the rising edge of the write strobe, while the chip is enabled, selects one of three read modes. These are plain array data, the identifier space, and the status register. The selected mode applies to every later read until another recognised command arrives. In identifier mode the address selects one of three codes: the manufacturer code, a device code fixed by the density parameter, or the lock code of one erase block. In status mode the returned byte is captured once, when the read enable becomes active, and is held until the read is ended.

All inputs are sampled on `clk`. A read is active while both `ce_n` and `oe_n` are low. The data bus `dout` and its per-bit enables `dout_oe` are registered, so they show the result one clock after the inputs are sampled. While the write state machine is busy and not suspended, a status read drives only bit 7. The other fifteen bits float.

Top module: `flash_rdmode_ctl`

## Requirements
- R1: After reset the mode is array read and `dout_oe` is 0.
- R2: In any cycle where `ce_n` or `oe_n` is sampled high, `dout_oe` is 0 one clock later. Otherwise the read result appears one clock after the inputs are sampled.
- R3: A command is taken from `din` when `we_n` is sampled rising while `ce_n` is low. 0xFF selects array read, 0x90 selects identifier read and 0x70 selects status read. The mode then persists across any number of reads.
- R4: A written byte other than 0xFF, 0x90 or 0x70 leaves the mode unchanged.
- R5: 0x90 is ignored while `wsm_busy` is 1 and `wsm_susp` is 0. It is accepted when the machine is idle or suspended.
- R6: In identifier mode, the word offset is `addr[BLK_W-1:1]`, and `addr[0]` has no effect. Offset 0 reads 0x89. Offset 1 reads the device code: 0x16, 0x17, 0x18 or 0x1D for a density of 32, 64, 128 or 256 Mbit.
- R7: In identifier mode, offset 2 reads the lock code of block `addr[ADDR_W-1:BLK_W]`. Bit 0 of that code equals `lock_bits[block]`, and bits 7:1 are 0. All other offsets read 0x00.
- R8: With `byte_mode`=0, identifier and status reads drive `dout[15:8]`=0x00 and `dout_oe`=0xFFFF. With `byte_mode`=1, only `dout_oe[7:0]` may be set.
- R9: The status byte is {ready, `sts_flags[6:0]`}, where ready = NOT(`wsm_busy` AND NOT `wsm_susp`). It is captured in the first cycle in which the read becomes active.
- R10: The captured status is held across changes of the status inputs until `oe_n` or `ce_n` is sampled high. A new read then captures afresh.
- R11: If the capture happened while busy and not suspended, `dout_oe` is 0x0080 and `dout[7]` is 0.
- R12: In array mode `dout` returns `arr_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, command taken on its rise |
| byte_mode | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Command byte |
| arr_rdata | input | 16 | Array data for the current address |
| wsm_busy | input | 1 | Write state machine running an operation |
| wsm_susp | input | 1 | Running operation is suspended |
| sts_flags | input | 7 | Status bits 6:0 from the write state machine |
| lock_bits | input | 2**(ADDR_W-BLK_W) | Lock state, one bit per block |
| dout | output | 16 | Read data |
| dout_oe | output | 16 | Per-bit output enable |

## Verification
The identifier table is read through several address patterns:
- odd and even byte addresses, which separate a decoder that uses A0 from one that ignores it;
- offset 2 in a locked and in an unlocked block, which shows whether the block index is taken from the upper address bits;
- an unused offset, which must read zero.

Status reads hold `oe_n` low while the status inputs change. Two kinds of release then follow: an `oe_n` pulse and a `ce_n` pulse. Together these separate a held capture from a transparent path. Busy, busy-suspended and idle captures separate the single-bit drive pattern from the full one. Command writes made while busy, and writes of unrecognised bytes, show whether the mode machine filters them.

// File: rtl/frm_pkg.sv
package frm_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_IDENT  = 2'd1,
        MODE_STATUS = 2'd2
    } rd_mode_e;

    typedef enum logic {
        LAT_OPEN = 1'b0,
        LAT_HELD = 1'b1
    } lat_state_e;

    typedef struct packed {
        logic       partial;
        logic [7:0] value;
    } stat_word_t;

    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_READ_ID     = 8'h90;
    localparam logic [7:0] CMD_READ_STATUS = 8'h70;
    localparam logic [7:0] MFR_CODE        = 8'h89;

    function automatic logic [7:0] dev_code(input int mbit);
        case (mbit)
            32:      return 8'h16;
            64:      return 8'h17;
            256:     return 8'h1D;
            default: return 8'h18;
        endcase
    endfunction

endpackage

// File: rtl/frm_cmd_fsm.sv
module frm_cmd_fsm
    import frm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_strobe,
    input  logic [7:0] wr_byte,
    input  logic       wsm_busy,
    input  logic       wsm_susp,
    output rd_mode_e   mode
);

    rd_mode_e mode_q;
    rd_mode_e mode_d;
    logic     id_allowed;

    assign id_allowed = !wsm_busy || wsm_susp;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_ARRAY;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        if (wr_strobe) begin
            unique case (mode_q)
                MODE_ARRAY, MODE_IDENT, MODE_STATUS: begin
                    if (wr_byte == CMD_READ_ARRAY)
                        mode_d = MODE_ARRAY;
                    else if (wr_byte == CMD_READ_STATUS)
                        mode_d = MODE_STATUS;
                    else if (wr_byte == CMD_READ_ID && id_allowed)
                        mode_d = MODE_IDENT;
                end
                default: mode_d = MODE_ARRAY;
            endcase
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/frm_status_latch.sv
module frm_status_latch
    import frm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       read_en,
    input  stat_word_t stat_now,
    output stat_word_t stat_q,
    output lat_state_e lat_state,
    output logic       capture
);

    lat_state_e st_q;
    lat_state_e st_d;
    stat_word_t hold_q;

    assign capture = (st_q == LAT_OPEN) && read_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= LAT_OPEN;
            hold_q <= '0;
        end else begin
            st_q <= st_d;
            if (capture) hold_q <= stat_now;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LAT_OPEN: if (read_en)  st_d = LAT_HELD;
            LAT_HELD: if (!read_en) st_d = LAT_OPEN;
            default:  st_d = LAT_OPEN;
        endcase
    end

    assign stat_q    = hold_q;
    assign lat_state = st_q;

endmodule

// File: rtl/frm_id_decode.sv
module frm_id_decode
    import frm_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int BLK_W        = 8,
    parameter int DENSITY_MBIT = 128,
    localparam int NUM_BLK     = 1 << (ADDR_W - BLK_W),
    localparam int OFS_W       = BLK_W - 1
) (
    input  logic [ADDR_W-1:1]  word_addr,
    input  logic [NUM_BLK-1:0] lock_bits,
    output logic [7:0]         id_byte
);

    localparam logic [7:0] DEV = dev_code(DENSITY_MBIT);

    logic [OFS_W-1:0]         offset;
    logic [ADDR_W-BLK_W-1:0]  blk;

    assign offset = word_addr[BLK_W-1:1];
    assign blk    = word_addr[ADDR_W-1:BLK_W];

    always_comb begin
        id_byte = 8'h00;
        if (offset == OFS_W'(0))      id_byte = MFR_CODE;
        else if (offset == OFS_W'(1)) id_byte = DEV;
        else if (offset == OFS_W'(2)) id_byte = {7'b0, lock_bits[blk]};
    end

endmodule

// File: rtl/flash_rdmode_ctl.sv
module flash_rdmode_ctl
    import frm_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int BLK_W        = 8,
    parameter int DENSITY_MBIT = 128
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ce_n,
    input  logic                             oe_n,
    input  logic                             we_n,
    input  logic                             byte_mode,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [7:0]                       din,
    input  logic [15:0]                      arr_rdata,
    input  logic                             wsm_busy,
    input  logic                             wsm_susp,
    input  logic [6:0]                       sts_flags,
    input  logic [(1<<(ADDR_W-BLK_W))-1:0]   lock_bits,
    output logic [15:0]                      dout,
    output logic [15:0]                      dout_oe
);

    localparam int          DATA_W   = 16;
    localparam logic [15:0] BIT7_EN  = 16'h0080;

    logic        we_q;
    logic        wr_strobe;
    logic        read_en;
    rd_mode_e    mode_q;
    lat_state_e  lat_state;
    logic        capture;
    stat_word_t  stat_now;
    stat_word_t  stat_q;
    stat_word_t  stat_sel;
    logic [7:0]  id_byte;
    logic [DATA_W-1:0] lane_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_n;
    end

    assign wr_strobe = !we_q && we_n && !ce_n;
    assign read_en   = !ce_n && !oe_n;

    assign stat_now.partial = wsm_busy && !wsm_susp;
    assign stat_now.value   = {!(wsm_busy && !wsm_susp), sts_flags};
    assign stat_sel         = capture ? stat_now : stat_q;

    generate
        for (genvar ln = 0; ln < DATA_W / 8; ln++) begin : g_lane
            if (ln == 0) begin : g_low
                assign lane_mask[7:0] = 8'hFF;
            end else begin : g_high
                assign lane_mask[ln*8 +: 8] = byte_mode ? 8'h00 : 8'hFF;
            end
        end
    endgenerate

    frm_cmd_fsm u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (wr_strobe),
        .wr_byte   (din),
        .wsm_busy  (wsm_busy),
        .wsm_susp  (wsm_susp),
        .mode      (mode_q)
    );

    frm_status_latch u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .read_en   (read_en),
        .stat_now  (stat_now),
        .stat_q    (stat_q),
        .lat_state (lat_state),
        .capture   (capture)
    );

    frm_id_decode #(
        .ADDR_W       (ADDR_W),
        .BLK_W        (BLK_W),
        .DENSITY_MBIT (DENSITY_MBIT)
    ) u_id (
        .word_addr (addr[ADDR_W-1:1]),
        .lock_bits (lock_bits),
        .id_byte   (id_byte)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || !read_en) begin
            dout    <= '0;
            dout_oe <= '0;
        end else begin
            unique case (mode_q)
                MODE_ARRAY: begin
                    dout    <= arr_rdata;
                    dout_oe <= lane_mask;
                end
                MODE_IDENT: begin
                    dout    <= {8'h00, id_byte};
                    dout_oe <= lane_mask;
                end
                MODE_STATUS: begin
                    dout    <= {8'h00, stat_sel.value};
                    dout_oe <= stat_sel.partial ? BIT7_EN : lane_mask;
                end
                default: begin
                    dout    <= '0;
                    dout_oe <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/flash_rdmode_chk.sv
module flash_rdmode_chk
    import frm_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        ce_n,
    input logic        oe_n,
    input logic        byte_mode,
    input logic        wsm_busy,
    input logic        wsm_susp,
    input logic [7:0]  din,
    input logic        wr_strobe,
    input rd_mode_e    mode,
    input lat_state_e  lat_state,
    input logic [15:0] dout,
    input logic [15:0] dout_oe
);

    assert_idle_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |=> (dout_oe == 16'h0000));

    assert_unknown_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && din != CMD_READ_ARRAY && din != CMD_READ_ID
         && din != CMD_READ_STATUS) |=> $stable(mode));

    assert_id_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && din == CMD_READ_ID && wsm_busy && !wsm_susp
         && mode != MODE_IDENT) |=> (mode != MODE_IDENT));

    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && mode != MODE_ARRAY && !byte_mode)
        |=> (dout[15:8] == 8'h00));

    assert_x8_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && byte_mode) |=> (dout_oe[15:8] == 8'h00));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_state == LAT_HELD && !ce_n && !oe_n && mode == MODE_STATUS
         && $past(mode) == MODE_STATUS) |=> $stable(dout));

    assert_busy_pattern_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STATUS && lat_state == LAT_OPEN && !ce_n && !oe_n
         && wsm_busy && !wsm_susp) |=> (dout_oe == 16'h0080 && !dout[7]));

endmodule

bind flash_rdmode_ctl flash_rdmode_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .byte_mode (byte_mode),
    .wsm_busy  (wsm_busy),
    .wsm_susp  (wsm_susp),
    .din       (din),
    .wr_strobe (wr_strobe),
    .mode      (mode_q),
    .lat_state (lat_state),
    .dout      (dout),
    .dout_oe   (dout_oe)
);

// File: tb/sim_flash_rdmode_ctl.sv
`timescale 1ns/1ps
module sim_flash_rdmode_ctl;

    localparam int ADDR_W = 12;
    localparam int BLK_W  = 8;
    localparam int NBLK   = 1 << (ADDR_W - BLK_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, byte_mode = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = '0;
    logic [15:0]       arr_rdata = 16'h0000;
    logic              wsm_busy = 1'b0, wsm_susp = 1'b0;
    logic [6:0]        sts_flags = '0;
    logic [NBLK-1:0]   lock_bits = '0;
    logic [15:0]       dout, dout_oe;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    flash_rdmode_ctl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DENSITY_MBIT(128)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .byte_mode(byte_mode), .addr(addr), .din(din), .arr_rdata(arr_rdata),
        .wsm_busy(wsm_busy), .wsm_susp(wsm_susp), .sts_flags(sts_flags),
        .lock_bits(lock_bits), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_cmd(input logic [7:0] b);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0; din = b;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
    endtask

    // single read: result sampled one clock after enables are sampled
    task automatic rd(input logic [ADDR_W-1:0] a, output logic [15:0] d, output logic [15:0] e);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); d = dout; e = dout_oe;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_reset();
        chk("R1 oe after reset", dout_oe, 16'h0000);
        arr_rdata = 16'hA55A;
        begin
            logic [15:0] d, e;
            rd(12'h010, d, e);
            chk("R1 array mode after reset", d, 16'hA55A);
        end
    endtask

    task automatic test_array();
        logic [15:0] d, e;
        wr_cmd(8'hFF);
        arr_rdata = 16'h1234; rd(12'h020, d, e);
        chk("R12 array data", d, 16'h1234);
        chk("R12 array oe", e, 16'hFFFF);
        arr_rdata = 16'hBEEF; rd(12'h021, d, e);
        chk("R3 mode persists", d, 16'hBEEF);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        chk("R2 oe_n high disables", dout_oe, 16'h0000);
        ce_n = 1'b1;
    endtask

    task automatic test_ident();
        logic [15:0] d, e;
        lock_bits = '0; lock_bits[5] = 1'b1;
        wr_cmd(8'h90);
        rd(12'h000, d, e); chk("R6 mfr code", d, 16'h0089);
        chk("R8 x16 oe", e, 16'hFFFF);
        rd(12'h001, d, e); chk("R6 A0 ignored", d, 16'h0089);
        rd(12'h002, d, e); chk("R6 device code", d, 16'h0018);
        rd(12'h003, d, e); chk("R6 device code odd", d, 16'h0018);
        rd(12'h504, d, e); chk("R7 locked block", d, 16'h0001);
        rd(12'h404, d, e); chk("R7 unlocked block", d, 16'h0000);
        rd(12'h506, d, e); chk("R7 other offset zero", d, 16'h0000);
        rd(12'h000, d, e); chk("R3 ident persists", d, 16'h0089);
    endtask

    task automatic test_unknown();
        logic [15:0] d, e;
        wr_cmd(8'h42);
        rd(12'h000, d, e); chk("R4 unknown cmd keeps ident", d, 16'h0089);
        wr_cmd(8'h00);
        rd(12'h002, d, e); chk("R4 zero byte keeps ident", d, 16'h0018);
    endtask

    task automatic test_reject();
        logic [15:0] d, e;
        wr_cmd(8'hFF);
        wsm_busy = 1'b1; wsm_susp = 1'b0;
        wr_cmd(8'h90);
        wsm_busy = 1'b0;
        arr_rdata = 16'hC0DE; rd(12'h000, d, e);
        chk("R5 ident rejected while busy", d, 16'hC0DE);
        wsm_busy = 1'b1; wsm_susp = 1'b1;
        wr_cmd(8'h90);
        rd(12'h000, d, e);
        chk("R5 ident accepted when suspended", d, 16'h0089);
        wsm_busy = 1'b0; wsm_susp = 1'b0;
    endtask

    task automatic test_status_latch();
        wr_cmd(8'h70);
        @(negedge clk); sts_flags = 7'h05; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        chk("R9 status value", dout, 16'h0085);
        chk("R8 status oe", dout_oe, 16'hFFFF);
        sts_flags = 7'h12; wsm_busy = 1'b1;
        @(negedge clk);
        chk("R10 held while oe low", dout, 16'h0085);
        @(negedge clk);
        chk("R10 held oe pattern", dout_oe, 16'hFFFF);
        wsm_busy = 1'b0; oe_n = 1'b1;
        @(negedge clk); oe_n = 1'b0;
        @(negedge clk);
        chk("R10 recapture after oe pulse", dout, 16'h0092);
        sts_flags = 7'h33; ce_n = 1'b1;
        @(negedge clk); ce_n = 1'b0;
        @(negedge clk);
        chk("R9 capture on ce edge", dout, 16'h00B3);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_busy();
        sts_flags = 7'h05; wsm_busy = 1'b1; wsm_susp = 1'b0;
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        chk("R11 busy oe", dout_oe, 16'h0080);
        chk("R11 busy bit7", {15'b0, dout[7]}, 16'h0000);
        wsm_busy = 1'b0;
        @(negedge clk);
        chk("R11 busy pattern held", dout_oe, 16'h0080);
        oe_n = 1'b1;
        @(negedge clk); oe_n = 1'b0;
        @(negedge clk);
        chk("R11 done full drive", dout_oe, 16'hFFFF);
        chk("R9 ready after done", dout, 16'h0085);
        oe_n = 1'b1; wsm_busy = 1'b1; wsm_susp = 1'b1;
        @(negedge clk); oe_n = 1'b0;
        @(negedge clk);
        chk("R9 suspended reads ready", dout, 16'h0085);
        chk("R11 suspended full drive", dout_oe, 16'hFFFF);
        ce_n = 1'b1; oe_n = 1'b1; wsm_busy = 1'b0; wsm_susp = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_x8();
        logic [15:0] d, e;
        byte_mode = 1'b1;
        wr_cmd(8'hFF);
        arr_rdata = 16'h5A3C; rd(12'h000, d, e);
        chk("R8 x8 array oe", e, 16'h00FF);
        wr_cmd(8'h90);
        rd(12'h000, d, e);
        chk("R8 x8 ident oe", e, 16'h00FF);
        chk("R6 x8 mfr code", d & 16'h00FF, 16'h0089);
        byte_mode = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_array();
        test_ident();
        test_unknown();
        test_reject();
        test_status_latch();
        test_busy();
        test_x8();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule